// File: doc/BRIEF.md
# Double-Width Iterative Unsigned Divider

This block divides an unsigned dividend of twice the operand width, presented as a high half and a low half, by an unsigned divisor of one operand width. It produces a quotient and a remainder of one operand width each. A two-bit size code picks the operand width for each operation: 8, 16, 32 or 64 bits. Input bits above the selected width are ignored.

An operation starts with a one-cycle `start` pulse while the block is not busy. The high half is taken as the first partial remainder, and the low half is kept left-aligned in a shift register. The block then runs one step per clock. In a single step it shifts in every low-half bit that leaves the partial remainder below the divisor, and each of those bits adds a zero quotient bit. It then aligns the leading set bits of the divisor and the partial remainder, with a one-place back-off when the aligned divisor is too large, and subtracts. The result is that each step retires a whole run of zero quotient bits followed by one set bit.

A zero divisor and a quotient too wide for the operand are both reported on the `done` pulse instead of a result. Neither error runs any step cycles.

Top module: `dwd_iter_div`

## Requirements
- R1: After reset, busy, done, quotient, remainder, div_by_zero and overflow are all 0.
- R2: The size code selects the operand width: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. Bits of dividend_hi, dividend_lo and divisor above that width have no effect. Quotient and remainder are zero above that width.
- R3: With no error, the dividend is dividend_hi·2^W + dividend_lo. At done, quotient equals the dividend divided by the divisor, rounded down, and remainder equals the dividend modulo the divisor.
- R4: A zero divisor (after masking) raises done in the cycle after the accepting edge. At that point div_by_zero is 1, overflow is 0, and quotient and remainder are 0.
- R5: A nonzero divisor with dividend_hi ≥ divisor raises done in the cycle after the accepting edge. At that point overflow is 1, div_by_zero is 0, and quotient and remainder are 0.
- R6: Without an error, let N be the number of set bits in the quotient, plus one if quotient bit 0 is clear. Done rises N cycles after the accepting edge. Busy is high in every cycle between the accepting edge and done, and the internal bit count falls on every step. N is never more than W.
- R7: Done lasts exactly one cycle, and busy and done are never high together. Outputs hold their values after done until the next start.
- R8: A start that arrives while busy is high is ignored. The operation in flight completes with its own timing and result.
- R9: Whenever done is high without an error, remainder < divisor. The partial remainder stays below the divisor on every step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when not busy |
| size | input | 2 | Operand width code (8/16/32/64) |
| dividend_hi | input | MAX_W | Upper half of the dividend |
| dividend_lo | input | MAX_W | Lower half of the dividend |
| divisor | input | MAX_W | Divisor |
| busy | output | 1 | Step cycles in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | MAX_W | Quotient, valid at done |
| remainder | output | MAX_W | Remainder, valid at done |
| div_by_zero | output | 1 | Divisor was zero |
| overflow | output | 1 | Quotient would not fit in W bits |

## Verification
Two situations are hard to reach from the ports. The first is the longest run, where every step retires exactly one quotient bit. The stimulus reaches it with a divisor of one and an all-ones low half at 64 bits. The second is the trailing flush step, which is only needed when the quotient ends in zeros. Operands are chosen so that their quotients end in ones, end in zeros, or are zero. A second start is injected mid-operation, and the bench model predicts the exact done cycle from the quotient's bit pattern, so any restart or extra step shows up as a timing mismatch.

// File: rtl/dwd_pkg.sv
package dwd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_STEP = 2'd1,
      ST_FIN  = 2'd2
   } dwd_state_e;

   // operand width for a size code, clamped to the widest supported width
   function automatic int unsigned size_bits(input logic [1:0] sz, input int unsigned maxw);
      int unsigned b;
      b = 32'd8 << sz;
      return (b > maxw) ? maxw : b;
   endfunction
endpackage

// File: rtl/dwd_msb_find.sv
module dwd_msb_find #(
   parameter int W  = 65,
   parameter int IW = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic [IW-1:0] pos
);
   always_comb begin
      pos = '0;
      for (int i = 0; i < W; i++) begin
         if (vec[i]) pos = IW'(i);
      end
   end
endmodule

// File: rtl/dwd_align_sub.sv
module dwd_align_sub #(
   parameter int W = 64
) (
   input  logic [W:0]   part,
   input  logic [W-1:0] dvs,
   output logic [W:0]   part_next,
   output logic [W-1:0] q_add
);
   localparam int PW = W + 1;
   localparam int IW = $clog2(PW);

   logic [IW-1:0] p_msb;
   logic [IW-1:0] d_msb;
   logic [W:0]    dv_ext;

   assign dv_ext = {1'b0, dvs};

   dwd_msb_find #(.W(PW)) u_pmsb (.vec(part),   .pos(p_msb));
   dwd_msb_find #(.W(PW)) u_dmsb (.vec(dv_ext), .pos(d_msb));

   always_comb begin
      logic [W:0]   aligned;
      logic [W-1:0] weight;
      int           sh;
      sh      = (p_msb > d_msb) ? (int'(p_msb) - int'(d_msb)) : 0;
      aligned = dv_ext << sh;
      weight  = W'(1) << sh;
      // back off one place when the leading-bit alignment overshoots
      if ((aligned > part) && (sh > 0)) begin
         aligned = aligned >> 1;
         weight  = weight >> 1;
      end
      if (part >= dv_ext) begin
         part_next = part - aligned;
         q_add     = weight;
      end else begin
         part_next = part;
         q_add     = '0;
      end
   end
endmodule

// File: rtl/dwd_shift_pick.sv
module dwd_shift_pick #(
   parameter int W  = 64,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  rem,
   input  logic [W-1:0]  dvs,
   input  logic [W-1:0]  lo_bits,
   input  logic [CW-1:0] left,
   output logic [CW-1:0] take,
   output logic [W:0]    part
);
   logic [W:0]   cpart [0:W];
   logic [W:0]   reach;
   logic [2*W-1:0] rem_ext;
   logic [2*W-1:0] lo_ext;
   logic [2*W-1:0] dv_ext;

   assign rem_ext = {{W{1'b0}}, rem};
   assign lo_ext  = {{W{1'b0}}, lo_bits};
   assign dv_ext  = {{W{1'b0}}, dvs};

   // candidate partial remainder after pulling in k low-half bits
   for (genvar k = 0; k <= W; k++) begin : g_cand
      logic [2*W-1:0] c;
      assign c        = (rem_ext << k) | (lo_ext >> (W - k));
      assign reach[k] = (c >= dv_ext) && (k <= int'(left));
      assign cpart[k] = c[W:0];
   end

   always_comb begin
      take = left;
      part = cpart[left];
      for (int k = W; k >= 0; k--) begin
         if (reach[k]) begin
            take = CW'(k);
            part = cpart[k];
         end
      end
   end
endmodule

// File: rtl/dwd_iter_div.sv
module dwd_iter_div #(
   parameter int MAX_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [1:0]       size,
   input  logic [MAX_W-1:0] dividend_hi,
   input  logic [MAX_W-1:0] dividend_lo,
   input  logic [MAX_W-1:0] divisor,
   output logic             busy,
   output logic             done,
   output logic [MAX_W-1:0] quotient,
   output logic [MAX_W-1:0] remainder,
   output logic             div_by_zero,
   output logic             overflow
);
   import dwd_pkg::*;

   localparam int CW = $clog2(MAX_W + 1);

   if (!(MAX_W == 8 || MAX_W == 16 || MAX_W == 32 || MAX_W == 64)) begin : g_bad_w
      $error("dwd_iter_div: MAX_W must be 8, 16, 32 or 64");
   end

   dwd_state_e       state;
   logic [MAX_W-1:0] q_r, rem_r, div_r, lo_r;
   logic [CW-1:0]    cnt_r;
   logic             dbz_r, ovf_r;

   logic [CW-1:0]    wsel;
   logic [MAX_W-1:0] mask, hi_m, lo_m, dv_m;
   logic             accept;

   logic [CW-1:0]    take;
   logic [MAX_W:0]   part, part_next;
   logic [MAX_W-1:0] q_add;
   logic [CW-1:0]    cnt_next;

   assign wsel   = CW'(size_bits(size, MAX_W));
   assign mask   = {MAX_W{1'b1}} >> (MAX_W - int'(wsel));
   assign hi_m   = dividend_hi & mask;
   assign lo_m   = dividend_lo & mask;
   assign dv_m   = divisor & mask;

   assign busy   = (state == ST_STEP);
   assign done   = (state == ST_FIN);
   assign accept = start && !busy;

   dwd_shift_pick #(.W(MAX_W), .CW(CW)) u_pick (
      .rem    (rem_r),
      .dvs    (div_r),
      .lo_bits(lo_r),
      .left   (cnt_r),
      .take   (take),
      .part   (part)
   );

   dwd_align_sub #(.W(MAX_W)) u_align (
      .part     (part),
      .dvs      (div_r),
      .part_next(part_next),
      .q_add    (q_add)
   );

   assign cnt_next = cnt_r - take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         q_r   <= '0;
         rem_r <= '0;
         div_r <= '0;
         lo_r  <= '0;
         cnt_r <= '0;
         dbz_r <= 1'b0;
         ovf_r <= 1'b0;
      end else if (accept) begin
         q_r   <= '0;
         dbz_r <= 1'b0;
         ovf_r <= 1'b0;
         div_r <= dv_m;
         lo_r  <= lo_m << (MAX_W - int'(wsel));
         if (dv_m == '0) begin
            dbz_r <= 1'b1;
            rem_r <= '0;
            cnt_r <= '0;
            state <= ST_FIN;
         end else if (hi_m >= dv_m) begin
            ovf_r <= 1'b1;
            rem_r <= '0;
            cnt_r <= '0;
            state <= ST_FIN;
         end else begin
            // first pass: high half is already below the divisor
            rem_r <= hi_m;
            cnt_r <= wsel;
            state <= ST_STEP;
         end
      end else begin
         case (state)
            ST_STEP: begin
               if (cnt_r == '0) begin
                  state <= ST_FIN;
               end else begin
                  q_r   <= (q_r << take) + q_add;
                  rem_r <= part_next[MAX_W-1:0];
                  lo_r  <= lo_r << take;
                  cnt_r <= cnt_next;
                  if (cnt_next == '0) state <= ST_FIN;
               end
            end
            ST_FIN:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign quotient    = q_r;
   assign remainder   = rem_r;
   assign div_by_zero = dbz_r;
   assign overflow    = ovf_r;

   // R7
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !done);

   // R4
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_by_zero |-> (!overflow && quotient == '0 && remainder == '0));

   // R6
   count_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start && cnt_r != '0) |=> (cnt_r < $past(cnt_r)));

   // R6
   take_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (take <= cnt_r));

   // R9
   rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (rem_r < div_r && !part_next[MAX_W]));

   // R9
   done_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !div_by_zero && !overflow) |-> (remainder < div_r));
endmodule

// File: tb/sim_dwd_iter_div.sv
module sim_dwd_iter_div;
   localparam int CLK_PERIOD = 10;
   localparam int MW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [1:0]    size = 2'd0;
   logic [MW-1:0] dividend_hi = '0, dividend_lo = '0, divisor = '0;
   logic          busy, done, div_by_zero, overflow;
   logic [MW-1:0] quotient, remainder;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dwd_iter_div #(.MAX_W(MW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .size(size),
      .dividend_hi(dividend_hi), .dividend_lo(dividend_lo), .divisor(divisor),
      .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
      .div_by_zero(div_by_zero), .overflow(overflow)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one operation: behavioural expectation, then cycle-by-cycle compare
   task automatic run_op(input logic [1:0] sz, input logic [63:0] hi, input logic [63:0] lo,
                         input logic [63:0] dv, input bit poke, input string tag);
      int          w;
      logic [63:0] msk, hm, lm, dm, eq, er;
      logic [127:0] dd, q128, r128;
      bit          e_dbz, e_ovf;
      int          n;
      int          j;
      w   = 8 << sz;
      msk = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
      hm  = hi & msk; lm = lo & msk; dm = dv & msk;
      e_dbz = (dm == 0);
      e_ovf = !e_dbz && (hm >= dm);
      eq = 0; er = 0; n = 0;
      if (!e_dbz && !e_ovf) begin
         dd   = ({64'd0, hm} << w) | {64'd0, lm};
         q128 = dd / {64'd0, dm};
         r128 = dd % {64'd0, dm};
         eq   = q128[63:0];
         er   = r128[63:0];
         n    = $countones(eq) + ((eq[0] == 1'b0) ? 1 : 0);
      end
      @(negedge clk);
      size = sz; dividend_hi = hi; dividend_lo = lo; divisor = dv; start = 1'b1;
      @(posedge clk);
      j = 0;
      forever begin
         @(negedge clk);
         if (j == 0) start = 1'b0;
         if (poke && j == 1) begin
            // R8: foreign start mid-operation
            start = 1'b1; size = 2'd0; dividend_hi = 0; dividend_lo = 64'h3; divisor = 64'h7;
         end
         if (poke && j == 2) start = 1'b0;
         // R6 / R7 busy and done timing
         chk(busy == (j < n), $sformatf("R6 busy %s cyc%0d", tag, j), {63'd0, busy}, {63'd0, (j < n)});
         chk(done == (j == n), $sformatf("R6 done %s cyc%0d", tag, j), {63'd0, done}, {63'd0, (j == n)});
         if (j >= n || j > 70) break;
         j++;
      end
      chk(quotient == eq, $sformatf("R3 quotient %s", tag), quotient, eq);
      chk(remainder == er, $sformatf("R3 remainder %s", tag), remainder, er);
      chk(div_by_zero == e_dbz, $sformatf("R4 div_by_zero %s", tag), {63'd0, div_by_zero}, {63'd0, e_dbz});
      chk(overflow == e_ovf, $sformatf("R5 overflow %s", tag), {63'd0, overflow}, {63'd0, e_ovf});
      if (!e_dbz && !e_ovf)
         chk(remainder < dm, $sformatf("R9 rem<div %s", tag), remainder, dm);
      @(negedge clk);
      // R7: single-cycle pulse, outputs held
      chk(!done && !busy, $sformatf("R7 pulse end %s", tag), {62'd0, busy, done}, 64'd0);
      chk(quotient == eq, $sformatf("R7 hold %s", tag), quotient, eq);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1
      chk(!busy && !done && !div_by_zero && !overflow, "R1 flags", {60'd0, busy, done, div_by_zero, overflow}, 64'd0);
      chk(quotient == 0 && remainder == 0, "R1 data", quotient | remainder, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R3 basic byte
      run_op(2'd0, 64'h12, 64'h34, 64'h56, 1'b0, "w8");
      // R2 upper bits ignored at 16 bits
      run_op(2'd1, 64'hFFFF_0000_0000_1234, 64'hABCD_0000_0000_5678, 64'h1111_0000_0000_9ABC, 1'b0, "R2 w16");
      run_op(2'd2, 64'h0123_4567, 64'h89AB_CDEF, 64'hFEDC_BA98, 1'b0, "w32");
      run_op(2'd3, 64'h0000_0123_4567_89AB, 64'hFFFF_FFFF_0000_0001, 64'h8000_0000_0000_0001, 1'b0, "w64");
      // R4 divisor masked to zero
      run_op(2'd2, 64'h5, 64'h6, 64'hFFFF_FFFF_0000_0000, 1'b0, "R4 dbz");
      // R5 boundary hi == divisor
      run_op(2'd1, 64'h00AB, 64'h0, 64'h00AB, 1'b0, "R5 ovf");
      // largest quotient, hi = divisor-1
      run_op(2'd0, 64'h0F, 64'hFF, 64'h10, 1'b0, "qmax w8");
      // zero quotient: single flush step
      run_op(2'd0, 64'h0, 64'h3, 64'hC8, 1'b0, "q0 w8");
      // quotient ending in zeros: trailing flush step
      run_op(2'd1, 64'h0, 64'h8000, 64'h1, 1'b0, "tz w16");
      // longest run: all-ones quotient at 64 bits
      run_op(2'd3, 64'h0, {64{1'b1}}, 64'h1, 1'b0, "R6 long");
      // R8 start while busy ignored
      run_op(2'd2, 64'h0000_1234, 64'hDEAD_BEEF, 64'h0001_0001, 1'b1, "R8 poke");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule